// File: doc/BRIEF.md
# Memory Sleep Entry and Exit Controller

This block decides when a synchronous memory may drop into its low-power sleep state and when it may come back. A single active-high sleep request arrives with no relation to the memory clock. The block brings it into the clock domain and then counts a fixed number of clock cycles before it declares the memory asleep. When the request is withdrawn, it counts a second fixed number of cycles before it lets the memory run again.

Three outputs go to the rest of the memory. The first is a flag that is set while the memory is asleep. The second is an enable that allows the other synchronous inputs through: it closes when the memory goes to sleep, which deselects the device, and it stays closed until the wake count has finished. The third forces the data outputs to high impedance while the memory is asleep. The block never clears stored data or the memory's own registers; it only gates them. If the request is withdrawn before the entry count finishes, entry is abandoned and the memory carries on with no wake delay. A read or write that is still in progress when sleep begins is not protected.

Top module: `lp_sleep_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release until a request is seen, `asleep_o`=0, `inputs_open_o`=1 and `dq_hiz_o`=0. Asserting `rst_n` while the memory is asleep returns these values at once.
- R2: Number the clock edges so that edge 1 is the first edge at which `sleep_req_i` is sampled high, and let the request be sampled high on edges 1..L. If L ≥ ENTRY_CYCLES, `asleep_o` goes to 1 after edge SYNC_STAGES+ENTRY_CYCLES (edge 4 with the defaults).
- R3: If L < ENTRY_CYCLES, entry is abandoned: `asleep_o` stays 0 and `inputs_open_o` stays 1 on every cycle.
- R4: Once set, `asleep_o` stays 1 while the request stays high, and clears after edge SYNC_STAGES+L+1.
- R5: `inputs_open_o` goes to 0 on the same edge at which `asleep_o` is set, and returns to 1 after edge SYNC_STAGES+L+WAKE_CYCLES.
- R6: `dq_hiz_o` is 1 exactly while `asleep_o` is 1.
- R7: Once the wake count has started, a new request does not stop it. With the request high on edges 1..P (P ≥ ENTRY_CYCLES), low on edge P+1 and high again from edge P+2 on, `asleep_o` is set again after edge P+SYNC_STAGES+WAKE_CYCLES+ENTRY_CYCLES, and `inputs_open_o` reopens for the cycles between the end of the wake count and that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock inside the block |
| sleep_req_i | input | 1 | Asynchronous active-high sleep request |
| asleep_o | output | 1 | Set while the memory is asleep |
| inputs_open_o | output | 1 | 1 lets the other synchronous inputs through; 0 gates them and deselects the device |
| dq_hiz_o | output | 1 | Forces the data outputs to high impedance |

## Verification
The bench sweeps the request pulse length from one cycle up to far beyond the entry count. A design that counted one cycle too few or too many would move the sleep edge or the reopen edge, and a design that ignored an abandoned entry would sleep on a pulse that is too short. A request that comes back during the wake count targets a controller that cuts the wake short or stays asleep. Reset is applied in the middle of sleep to catch state that is not cleared asynchronously. Two instances with different synchronizer depths and entry and wake counts run side by side, so that latencies which are only right for the defaults show up.

// File: rtl/lp_sleep_pkg.sv
package lp_sleep_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_ENTER  = 2'd1,
    ST_ASLEEP = 2'd2,
    ST_WAKE   = 2'd3
  } sleep_st_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lp_sleep_rst_sync.sv
module lp_sleep_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  // asynchronous assertion, release walks through the chain on clk
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[TOP];

endmodule

// File: rtl/lp_sleep_req_sync.sv
module lp_sleep_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async_i,
  output logic req_sync_o
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= {stg_q[STAGES-2:0], req_async_i};
    end
  end

  assign req_sync_o = stg_q[TOP];

endmodule

// File: rtl/lp_sleep_fsm.sv
module lp_sleep_fsm
  import lp_sleep_pkg::*;
#(
  parameter int ENTRY_CYCLES = 2,
  parameter int WAKE_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  output logic asleep_o,
  output logic accept_o
);

  localparam int                CNT_MAX = max_int(ENTRY_CYCLES, WAKE_CYCLES);
  localparam int                CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0]  E_LAST  = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0]  W_LAST  = CNT_W'(WAKE_CYCLES - 1);
  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

  sleep_st_e        st_q, st_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             st_en, cnt_en, cnt_ld, cnt_inc;

  // next-state logic
  always_comb begin
    st_nxt  = st_q;
    cnt_ld  = 1'b0;
    cnt_inc = 1'b0;
    unique case (st_q)
      ST_AWAKE: begin
        if (req_s) begin
          st_nxt = ST_ENTER;
          cnt_ld = 1'b1;
        end
      end
      ST_ENTER: begin
        if (!req_s)               st_nxt  = ST_AWAKE;   // abandon entry, no wake delay
        else if (cnt_q == E_LAST) st_nxt  = ST_ASLEEP;
        else                      cnt_inc = 1'b1;
      end
      ST_ASLEEP: begin
        if (!req_s) begin
          st_nxt = ST_WAKE;
          cnt_ld = 1'b1;
        end
      end
      ST_WAKE: begin
        if (cnt_q == W_LAST) st_nxt  = ST_AWAKE;        // request ignored until done
        else                 cnt_inc = 1'b1;
      end
      default: st_nxt = ST_AWAKE;
    endcase
  end

  assign st_en   = (st_nxt != st_q);
  assign cnt_en  = cnt_ld | cnt_inc;
  assign cnt_nxt = cnt_ld ? CNT_ONE : cnt_q + CNT_ONE;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_AWAKE;
    end else if (st_en) begin
      st_q <= st_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign asleep_o = (st_q == ST_ASLEEP);
  assign accept_o = (st_q == ST_AWAKE) || (st_q == ST_ENTER);

  // R2: sleep is reached only from the entry count with the request still high
  p_entry_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_o) |-> ($past(req_s) && ($past(st_q) == ST_ENTER)));

  // R2: entry counter stays inside its window
  p_enter_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ENTER) |-> ((cnt_q >= CNT_ONE) && (cnt_q <= E_LAST)));

  // R3: a withdrawn request during entry returns straight to normal operation
  p_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ENTER && !req_s) |=> (st_q == ST_AWAKE && accept_o && !asleep_o));

  // R4: sleep holds while the synchronized request stays high
  p_hold_asleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_o && req_s) |=> asleep_o);

  // R5: inputs reopen only at the end of the wake count
  p_reopen_after_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accept_o) |-> (($past(st_q) == ST_WAKE) && ($past(cnt_q) == W_LAST)));

  // R7: the wake count runs to completion regardless of the request
  p_wake_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAKE && cnt_q != W_LAST) |=> (st_q == ST_WAKE));

endmodule

// File: rtl/lp_sleep_ctrl.sv
module lp_sleep_ctrl #(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 2,
  parameter int WAKE_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req_i,
  output logic asleep_o,
  output logic inputs_open_o,
  output logic dq_hiz_o
);

  localparam int RST_STAGES = 2;

  logic rst_int_n;
  logic req_s;
  logic asleep;
  logic accept;

  lp_sleep_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  lp_sleep_req_sync #(
    .STAGES (SYNC_STAGES)
  ) u_req_sync (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_async_i (sleep_req_i),
    .req_sync_o  (req_s)
  );

  lp_sleep_fsm #(
    .ENTRY_CYCLES (ENTRY_CYCLES),
    .WAKE_CYCLES  (WAKE_CYCLES)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req_s    (req_s),
    .asleep_o (asleep),
    .accept_o (accept)
  );

  assign asleep_o      = asleep;
  assign inputs_open_o = accept;
  assign dq_hiz_o      = asleep;

  // R6: outputs are never driven while the device is open for inputs in sleep
  p_hiz_gated_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    dq_hiz_o |-> !inputs_open_o);

endmodule

// File: tb/test_lp_sleep_ctrl.sv
`timescale 1ns/1ps
module test_lp_sleep_ctrl;

  localparam int AS = 2, AE = 2, AW = 2;
  localparam int BS = 3, BE = 3, BW = 4;

  logic clk;
  logic rst_n;
  logic req;
  logic a_sl, a_op, a_hz;
  logic b_sl, b_op, b_hz;
  int   n_chk;
  int   n_bad;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  lp_sleep_ctrl i_lp_sleep_ctrl (
    .clk (clk), .rst_n (rst_n), .sleep_req_i (req),
    .asleep_o (a_sl), .inputs_open_o (a_op), .dq_hiz_o (a_hz)
  );

  lp_sleep_ctrl #(.SYNC_STAGES(BS), .ENTRY_CYCLES(BE), .WAKE_CYCLES(BW)) i_lp_sleep_ctrl_alt (
    .clk (clk), .rst_n (rst_n), .sleep_req_i (req),
    .asleep_o (b_sl), .inputs_open_o (b_op), .dq_hiz_o (b_hz)
  );

  task automatic cmp(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  // sleep flag, open enable and hi-Z of both instances against expectations
  task automatic check_both(input string tag, input bit a_sleep, input bit a_closed,
                            input bit b_sleep, input bit b_closed);
    cmp(tag,  "A asleep", a_sl, a_sleep);
    cmp("R5", "A open",   a_op, !a_closed);
    cmp("R6", "A hiz",    a_hz, a_sleep);
    cmp(tag,  "B asleep", b_sl, b_sleep);
    cmp("R5", "B open",   b_op, !b_closed);
    cmp("R6", "B hiz",    b_hz, b_sleep);
  endtask

  function automatic bit pulse_sleep(int s, int e, int l, int k);
    return (l >= e) && (k >= s + e) && (k <= s + l);
  endfunction

  function automatic bit pulse_closed(int s, int e, int w, int l, int k);
    return (l >= e) && (k >= s + e) && (k <= s + l + w - 1);
  endfunction

  function automatic bit rr_sleep(int s, int e, int w, int p, int k);
    return ((k >= s + e) && (k <= s + p)) || (k >= p + s + w + e);
  endfunction

  function automatic bit rr_closed(int s, int e, int w, int p, int k);
    return ((k >= s + e) && (k <= p + s + w - 1)) || (k >= p + s + w + e);
  endfunction

  // R2 R3 R4 R5 R6: request held for l sampling edges
  task automatic run_pulse(input int l);
    string tag;
    tag = (l < AE) ? "R3" : "R2/R4";
    @(negedge clk) req = 1'b1;
    for (int k = 1; k <= l + 14; k++) begin
      @(negedge clk);
      check_both(tag, pulse_sleep(AS, AE, l, k), pulse_closed(AS, AE, AW, l, k),
                 pulse_sleep(BS, BE, l, k), pulse_closed(BS, BE, BW, l, k));
      if (k == l) req = 1'b0;
    end
  endtask

  // R7: request returns during the wake count
  task automatic run_rereq(input int p);
    @(negedge clk) req = 1'b1;
    for (int k = 1; k <= p + 14; k++) begin
      @(negedge clk);
      check_both("R7", rr_sleep(AS, AE, AW, p, k), rr_closed(AS, AE, AW, p, k),
                 rr_sleep(BS, BE, BW, p, k), rr_closed(BS, BE, BW, p, k));
      if (k == p)     req = 1'b0;
      if (k == p + 1) req = 1'b1;
    end
    req = 1'b0;
    repeat (20) @(negedge clk);
    check_both("R7", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    req   = 1'b0;
    repeat (3) @(negedge clk);
    check_both("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    req = 1'b1;                                   // request held in reset has no effect
    repeat (8) @(negedge clk);
    check_both("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    req = 1'b0;
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_both("R1", 1'b0, 1'b0, 1'b0, 1'b0);

    for (int l = 1; l <= 10; l++) begin
      run_pulse(l);
      repeat (5) @(negedge clk);
    end
    run_pulse(25);
    repeat (5) @(negedge clk);

    run_rereq(3);
    run_rereq(5);

    // R1: reset in the middle of sleep
    req = 1'b1;
    repeat (15) @(negedge clk);
    check_both("R4", 1'b1, 1'b1, 1'b1, 1'b1);
    rst_n = 1'b0;
    #1;
    check_both("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk) req = 1'b0;
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_both("R1", 1'b0, 1'b0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule